// File: doc/BRIEF.md
# Configurable Quasi-Bidirectional Port

An eight-bit general-purpose port for a small processor core. It holds an output latch that the core writes either as a whole byte or one bit at a time. From that latch and a few override inputs it works out, for every pin, which of four pad controls to enable: pull low, drive high strongly, weak pull-up, or none, in which case the pin floats. A parameter selects one of four flavours. The first is an open-drain port that becomes a strong address/data bus during external memory cycles. The second is a plain quasi-bidirectional port. The third is quasi-bidirectional and carries the high address byte during external cycles. The fourth is quasi-bidirectional, and each of its bits can hand its pin to an alternate peripheral function.

The core reads the port in one of two ways. Read-modify-write instructions read the latch, so a pin that an external load holds low does not corrupt bits that are written back. Plain reads take the pin levels through a two-flop synchronizer. To use a pin as an input, the core writes 1 to its latch bit. The pin is then never actively pulled low, and an outside source can set its level.

Top module: `qport`

## Requirements
- R1: After reset every latch bit is 1 and the synchronized pin read is all ones. No pin is pulled low, and no pin is driven high strongly.
- R2: A byte write sets the latch to the written byte on the next clock edge.
- R3: A bit write changes only the latch bit it selects, and the other bits keep their values. When a byte write and a bit write arrive in the same cycle, the bit write decides its own bit and the byte write decides the rest.
- R4: The latch read returns the latch contents no matter what level the pins have.
- R5: The pin read returns the sensed pin levels exactly two clock edges after they change.
- R6: In the open-drain flavour (FLAVOR=0) with the bus idle, a latch bit of 0 pulls its pin low. A latch bit of 1 leaves the pin floating, with no pull-up and no high drive.
- R7: In the open-drain flavour, while the bus is active each pin is driven strongly to its bus_out bit: 1 drives high, 0 pulls low. From the following edge on the latch holds all ones, and writes have no effect on it.
- R8: In the quasi flavours (FLAVOR=1, 2, 3), when no override is active, a latch bit of 1 enables only the weak pull-up and a latch bit of 0 only pulls low. No pin is ever driven high strongly.
- R9: In the high-address flavour (FLAVOR=2), while the bus is active the pins are driven strongly to bus_out and the latch keeps its value. When the bus goes idle, the pins follow the latch again.
- R10: In the alternate-function flavour (FLAVOR=3), a bit with alt_sel=1 follows alt_out (1 gives the pull-up, 0 pulls low), but only while its latch bit is 1. If its latch bit is 0, the pin is pulled low.
- R11: No pin ever has its low drive enabled at the same time as its high drive or its pull-up.
- R12: The bus inputs have no effect in the flavours without a bus (1 and 3). The alternate-select inputs have no effect in flavours 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_byte_en | input | 1 | Write the whole latch |
| wr_byte_data | input | W | Byte to write |
| wr_bit_en | input | 1 | Write one latch bit |
| wr_bit_sel | input | SW | Index of the bit to write |
| wr_bit_val | input | 1 | Value of the bit to write |
| bus_mode | input | 1 | External memory cycle in progress |
| bus_out | input | W | Address/data byte for the pins during bus cycles |
| alt_sel | input | W | Per-bit alternate function select |
| alt_out | input | W | Per-bit alternate function output |
| pin_in | input | W | Sensed pin levels |
| latch_q | output | W | Latch read for read-modify-write |
| pin_q | output | W | Synchronized pin read |
| drv_low | output | W | Pull pin low |
| drv_high | output | W | Drive pin high strongly |
| pull_up | output | W | Enable weak pull-up |

## Verification
The hardest case to reach from the ports is a latch and its pins that disagree: the latch holds 1 while an external load keeps the pin low. The bench sets this up by writing all ones and then forcing pin_in low on some bits. It checks that the latch read stays at all ones while the pin read shows the low bits after exactly two edges. A second hard case is a write that arrives while the open-drain port is in a bus cycle. The bench issues that write while bus_mode is high and checks that the latch remains all ones.

// File: rtl/qport.sv
module qport #(
  parameter int W = 8,
  parameter int FLAVOR = 1,
  parameter int SW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_byte_en,
  input  logic [W-1:0]  wr_byte_data,
  input  logic          wr_bit_en,
  input  logic [SW-1:0] wr_bit_sel,
  input  logic          wr_bit_val,
  input  logic          bus_mode,
  input  logic [W-1:0]  bus_out,
  input  logic [W-1:0]  alt_sel,
  input  logic [W-1:0]  alt_out,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  latch_q,
  output logic [W-1:0]  pin_q,
  output logic [W-1:0]  drv_low,
  output logic [W-1:0]  drv_high,
  output logic [W-1:0]  pull_up
);
  localparam bit IS_OD  = (FLAVOR == 0);
  localparam bit IS_HA  = (FLAVOR == 2);
  localparam bit IS_ALT = (FLAVOR == 3);

  logic [W-1:0] lat, lat_nxt, eff, sync1;
  logic bus_act;

  assign bus_act = bus_mode && (IS_OD || IS_HA);

  always_comb begin
    lat_nxt = lat;
    if (wr_byte_en) lat_nxt = wr_byte_data;
    if (wr_bit_en)  lat_nxt[wr_bit_sel] = wr_bit_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                lat <= '1;
    else if (IS_OD && bus_mode) lat <= '1;
    else                       lat <= lat_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '1;
      pin_q <= '1;
    end else begin
      sync1 <= pin_in;
      pin_q <= sync1;
    end
  end

  assign eff      = IS_ALT ? (lat & (~alt_sel | alt_out)) : lat;
  assign latch_q  = lat;
  assign drv_high = bus_act ? bus_out  : '0;
  assign drv_low  = bus_act ? ~bus_out : ~eff;
  assign pull_up  = (bus_act || IS_OD) ? '0 : eff;
endmodule

// File: rtl/qport_chk.sv
module qport_chk #(
  parameter int W = 8,
  parameter int FLAVOR = 1,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_byte_en,
  input logic [W-1:0]  wr_byte_data,
  input logic          wr_bit_en,
  input logic [SW-1:0] wr_bit_sel,
  input logic          wr_bit_val,
  input logic          bus_mode,
  input logic [W-1:0]  alt_sel,
  input logic [W-1:0]  pin_in,
  input logic [W-1:0]  latch_q,
  input logic [W-1:0]  pin_q,
  input logic [W-1:0]  drv_low,
  input logic [W-1:0]  drv_high,
  input logic [W-1:0]  pull_up
);
  logic [1:0] age;
  logic [W-1:0] bmask;
  logic od_bus, ha_bus;
  assign bmask  = W'(1) << wr_bit_sel;
  assign od_bus = (FLAVOR == 0) && bus_mode;
  assign ha_bus = (FLAVOR == 2) && bus_mode;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;

  // R11
  drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((drv_low & drv_high) == '0) && ((drv_low & pull_up) == '0));

  // R2
  byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_byte_en && !wr_bit_en && !od_bus) |=> (latch_q == $past(wr_byte_data)));

  // R3
  bit_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bit_en && !wr_byte_en && !od_bus) |=>
      (((latch_q ^ $past(latch_q)) & ~$past(bmask)) == '0) &&
      (latch_q[$past(wr_bit_sel)] == $past(wr_bit_val)));

  // R5
  pin_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (pin_q == $past(pin_in, 2)));

  // R7
  od_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    od_bus |=> (latch_q == '1));

  // R9
  ha_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ha_bus && !wr_byte_en && !wr_bit_en) |=> $stable(latch_q));

  // R8
  quasi_nohigh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (FLAVOR != 0 && !ha_bus) |-> (drv_high == '0));

  // R10
  alt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (FLAVOR == 3) |-> ((~latch_q & ~drv_low) == '0));
endmodule

bind qport qport_chk #(.W(W), .FLAVOR(FLAVOR), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_byte_en(wr_byte_en), .wr_byte_data(wr_byte_data),
  .wr_bit_en(wr_bit_en), .wr_bit_sel(wr_bit_sel), .wr_bit_val(wr_bit_val),
  .bus_mode(bus_mode), .alt_sel(alt_sel), .pin_in(pin_in), .latch_q(latch_q),
  .pin_q(pin_q), .drv_low(drv_low), .drv_high(drv_high), .pull_up(pull_up)
);

// File: tb/qport_tb.sv
`timescale 1ns/1ps
module qport_tb;
  localparam int W = 8;
  logic clk = 0, rst_n = 0;
  logic wr_byte_en = 0, wr_bit_en = 0, wr_bit_val = 0, bus_mode = 0;
  logic [2:0] wr_bit_sel = 0;
  logic [W-1:0] wr_byte_data = 0, bus_out = 0, alt_sel = 0, alt_out = 0, pin_in = '1;
  logic [W-1:0] lq[4], pq[4], dl[4], dh[4], pu[4];
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  qport #(.W(W), .FLAVOR(0)) u_od (.clk(clk), .rst_n(rst_n), .wr_byte_en(wr_byte_en),
    .wr_byte_data(wr_byte_data), .wr_bit_en(wr_bit_en), .wr_bit_sel(wr_bit_sel),
    .wr_bit_val(wr_bit_val), .bus_mode(bus_mode), .bus_out(bus_out), .alt_sel(alt_sel),
    .alt_out(alt_out), .pin_in(pin_in), .latch_q(lq[0]), .pin_q(pq[0]), .drv_low(dl[0]),
    .drv_high(dh[0]), .pull_up(pu[0]));
  qport #(.W(W), .FLAVOR(1)) u_qb (.clk(clk), .rst_n(rst_n), .wr_byte_en(wr_byte_en),
    .wr_byte_data(wr_byte_data), .wr_bit_en(wr_bit_en), .wr_bit_sel(wr_bit_sel),
    .wr_bit_val(wr_bit_val), .bus_mode(bus_mode), .bus_out(bus_out), .alt_sel(alt_sel),
    .alt_out(alt_out), .pin_in(pin_in), .latch_q(lq[1]), .pin_q(pq[1]), .drv_low(dl[1]),
    .drv_high(dh[1]), .pull_up(pu[1]));
  qport #(.W(W), .FLAVOR(2)) u_ha (.clk(clk), .rst_n(rst_n), .wr_byte_en(wr_byte_en),
    .wr_byte_data(wr_byte_data), .wr_bit_en(wr_bit_en), .wr_bit_sel(wr_bit_sel),
    .wr_bit_val(wr_bit_val), .bus_mode(bus_mode), .bus_out(bus_out), .alt_sel(alt_sel),
    .alt_out(alt_out), .pin_in(pin_in), .latch_q(lq[2]), .pin_q(pq[2]), .drv_low(dl[2]),
    .drv_high(dh[2]), .pull_up(pu[2]));
  qport #(.W(W), .FLAVOR(3)) u_dut (.clk(clk), .rst_n(rst_n), .wr_byte_en(wr_byte_en),
    .wr_byte_data(wr_byte_data), .wr_bit_en(wr_bit_en), .wr_bit_sel(wr_bit_sel),
    .wr_bit_val(wr_bit_val), .bus_mode(bus_mode), .bus_out(bus_out), .alt_sel(alt_sel),
    .alt_out(alt_out), .pin_in(pin_in), .latch_q(lq[3]), .pin_q(pq[3]), .drv_low(dl[3]),
    .drv_high(dh[3]), .pull_up(pu[3]));

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr_byte(logic [W-1:0] d);
    wr_byte_en = 1; wr_byte_data = d; step(); wr_byte_en = 0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) begin
      chk("R1", "latch", lq[i], 8'hFF);
      chk("R1", "pin read", pq[i], 8'hFF);
      chk("R1", "low drive", dl[i], 8'h00);
      chk("R1", "high drive", dh[i], 8'h00);
    end
    chk("R6", "od pullup idle", pu[0], 8'h00);
    chk("R8", "qb pullup", pu[1], 8'hFF);
  endtask

  task automatic t_byte();
    wr_byte(8'hA5);
    for (int i = 0; i < 4; i++) chk("R2", "latch after byte", lq[i], 8'hA5);
    chk("R6", "od low", dl[0], 8'h5A);
    chk("R6", "od high", dh[0], 8'h00);
    chk("R6", "od pullup", pu[0], 8'h00);
    chk("R8", "qb pullup", pu[1], 8'hA5);
    chk("R8", "qb low", dl[1], 8'h5A);
    chk("R8", "ha high", dh[2], 8'h00);
  endtask

  task automatic t_bit();
    wr_bit_en = 1; wr_bit_sel = 3'd2; wr_bit_val = 0; step();
    chk("R3", "clear bit2", lq[1], 8'hA1);
    wr_bit_sel = 3'd6; wr_bit_val = 1; step();
    chk("R3", "set bit6", lq[1], 8'hE1);
    wr_byte_en = 1; wr_byte_data = 8'h00; wr_bit_sel = 3'd7; wr_bit_val = 1; step();
    wr_byte_en = 0; wr_bit_en = 0;
    chk("R3", "byte plus bit", lq[2], 8'h80);
  endtask

  task automatic t_rmw();
    wr_byte(8'hFF);
    pin_in = 8'h0F; step();
    chk("R4", "latch vs low pin", lq[1], 8'hFF);
    chk("R5", "pin after one edge", pq[1], 8'hFF);
    step();
    chk("R5", "pin after two edges", pq[1], 8'h0F);
    chk("R4", "latch still ones", lq[3], 8'hFF);
    pin_in = 8'hFF; step(); step();
    chk("R5", "pin restored", pq[0], 8'hFF);
  endtask

  task automatic t_bus();
    wr_byte(8'h3C);
    bus_mode = 1; bus_out = 8'h96; #1;
    chk("R7", "od bus high", dh[0], 8'h96);
    chk("R7", "od bus low", dl[0], 8'h69);
    chk("R9", "ha bus high", dh[2], 8'h96);
    chk("R12", "qb ignores bus", dh[1], 8'h00);
    chk("R12", "qb pullup in bus", pu[1], 8'h3C);
    step();
    chk("R7", "od latch filled", lq[0], 8'hFF);
    chk("R9", "ha latch held", lq[2], 8'h3C);
    chk("R12", "alt port ignores bus", dl[3], 8'hC3);
    wr_byte(8'h11);
    chk("R7", "od write blocked", lq[0], 8'hFF);
    bus_mode = 0; #1;
    chk("R9", "ha back to latch low", dl[2], 8'hEE);
    chk("R9", "ha back to latch pull", pu[2], 8'h11);
    chk("R6", "od floats after bus", dl[0] | dh[0] | pu[0], 8'h00);
  endtask

  task automatic t_alt();
    wr_byte(8'hF0);
    alt_sel = 8'hCC; alt_out = 8'h0A; #1;
    chk("R10", "alt pullup", pu[3], 8'h30);
    chk("R10", "alt low", dl[3], 8'hCF);
    alt_out = 8'hFF; #1;
    chk("R10", "alt gated by latch", dl[3], 8'h0F);
    chk("R12", "qb ignores alt", pu[1], 8'hF0);
    chk("R12", "ha ignores alt", dl[2], 8'h0F);
    chk("R12", "od ignores alt", dl[0], 8'h0F);
    alt_sel = 0; alt_out = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    t_reset();
    t_byte();
    t_bit();
    t_rmw();
    t_bus();
    t_alt();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule